// File: doc/BRIEF.md
# Reference/Oscillator Count Snapshot with Dithered DAC Code

This block sits beside a frequency synthesiser whose control loop runs in software. It runs two free counters, one on the reference clock and one on the oscillator being steered. A one-cycle request on the reference side stores both counts in the same reference edge, so software always reads a pair that belongs together. The oscillator count crosses into the reference domain as a Gray code through a two-flop synchroniser, and the snapshot takes that synchronised value.

The block also drives the code for the oscillator's DAC. Each reference cycle an N-bit phase accumulator adds a fractional word. If the add carries, the output is X+1 for that cycle; otherwise it is X. Over one accumulator period of 2^N cycles the average code is therefore X plus the fraction over 2^N. There is no waveform table. The output keeps X as its base level and now and then swaps in one X+1 cycle. New X and fraction values go into holding registers and move into use only at a period boundary, so a period never mixes two settings.

The request, load and snapshot pins are plain control and status signals. No stream passes through the block, so there is no valid/ready pairing and no back-pressure. The snapshot outputs hold until the next request.

Top module: `cnt_pair_dither`

## Requirements
- R1: While reset is applied, dac_code, snap_ref, snap_osc and snap_valid are all zero.
- R2: snap_ref equals the number of reference edges since reset, counted before the edge that samples snap_req high. The reference counter starts at 0 after reset.
- R3: snap_osc is the count of oscillator edges since reset, seen through the synchroniser. It is never ahead of the true count and trails it by only a few oscillator cycles. The internal Gray value changes by at most one bit per oscillator edge.
- R4: After a request edge, snap_valid is 0 for one cycle and then 1. snap_ref, snap_osc and snap_valid do not change again until the next request.
- R5: dac_code always equals X or X+1, where X is the base code in use.
- R6: The accumulator restarts at 0 at the start of each period. At step i of a period (i = 1..2^N) with fraction f, dac_code = X + floor(i*f/2^N) - floor((i-1)*f/2^N).
- R7: Over every full period of 2^N reference cycles, the number of X+1 codes equals the fraction word exactly.
- R8: A load with cfg_load high only fills the holding registers. The values in use change only on the last edge of a period, and changes on base_in or frac_in without cfg_load have no effect.
- R9: dac_code is one bit wider than base_in, so X at its maximum with a carry gives X+1 and does not wrap to 0.
- R10: With a fraction of 0, dac_code stays at X for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; runs the reference counter, snapshot and dither logic |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| osc_clk | input | 1 | Clock from the controlled oscillator |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| snap_req | input | 1 | Capture both counts on this reference edge |
| cfg_load | input | 1 | Write base_in and frac_in into the holding registers |
| base_in | input | CODE_W | Integer base code X |
| frac_in | input | ACC_W | Fraction word added each cycle to the accumulator |
| snap_ref | output | CNT_W | Captured reference count |
| snap_osc | output | CNT_W | Captured synchronised oscillator count |
| snap_valid | output | 1 | High from one cycle after a capture until the next request |
| dac_code | output | CODE_W+1 | Dithered DAC code, X or X+1 |

## Verification
A wrong accumulator state shows within one period: the X+1 count for the period misses the fraction, and the cycle-by-cycle carry positions move away from the floor formula from the first wrong step. A holding or active register updated at the wrong time shows as a code outside {X, X+1} or a period that uses the new setting too early. A fault in the snapshot path shows on the first request, as a reference count off by one, an oscillator count ahead of the true count, or outputs that move while no request is made.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int MAX_W = 32;

  function automatic logic [MAX_W-1:0] to_gray(input logic [MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [MAX_W-1:0] from_gray(input logic [MAX_W-1:0] g);
    logic [MAX_W-1:0] b;
    b[MAX_W-1] = g[MAX_W-1];
    for (int k = MAX_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction
endpackage

// File: rtl/cpm_osc_counter.sv
module cpm_osc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  output logic [CNT_W-1:0] gray_o
);
  import cpm_pkg::*;

  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;
  logic [MAX_W-1:0] gray_wide;

  assign bin_nx    = bin_q + CNT_W'(1);
  assign gray_wide = to_gray(MAX_W'(bin_nx));

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= gray_wide[CNT_W-1:0];
    end
  end

  // R3
  gray_step_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/cpm_gray_sync.sv
module cpm_gray_sync #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  import cpm_pkg::*;

  logic [CNT_W-1:0] meta_q;
  logic [CNT_W-1:0] sync_q;
  logic [MAX_W-1:0] bin_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  assign bin_wide = from_gray(MAX_W'(sync_q));
  assign bin_o    = bin_wide[CNT_W-1:0];
endmodule

// File: rtl/cpm_dither.sv
module cpm_dither #(
  parameter int ACC_W  = 8,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] base_i,
  input  logic [ACC_W-1:0]  frac_i,
  output logic [CODE_W:0]   code_o
);
  localparam int OUT_W = CODE_W + 1;

  logic [CODE_W-1:0] base_hold, base_act;
  logic [ACC_W-1:0]  frac_hold, frac_act;
  logic [ACC_W-1:0]  acc_q, phase_q;
  logic [ACC_W:0]    sum;
  logic              wrap;

  assign sum  = {1'b0, acc_q} + {1'b0, frac_act};
  assign wrap = (phase_q == {ACC_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hold <= '0;
      frac_hold <= '0;
      base_act  <= '0;
      frac_act  <= '0;
      acc_q     <= '0;
      phase_q   <= '0;
      code_o    <= '0;
    end else begin
      if (cfg_load) begin
        base_hold <= base_i;
        frac_hold <= frac_i;
      end
      acc_q   <= sum[ACC_W-1:0];
      phase_q <= phase_q + ACC_W'(1);
      code_o  <= {1'b0, base_act} + OUT_W'(sum[ACC_W]);
      if (wrap) begin
        base_act <= base_hold;
        frac_act <= frac_hold;
      end
    end
  end

  // R5
  two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == {1'b0, $past(base_act)}) ||
    (code_o == ({1'b0, $past(base_act)} + OUT_W'(1))));

  // R8
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != '0) |-> ($stable(base_act) && $stable(frac_act)));

  // R7
  period_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) |-> (acc_q == '0));
endmodule

// File: rtl/cnt_pair_dither.sv
module cnt_pair_dither #(
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 8,
  parameter int CODE_W = 10
) (
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic              osc_clk,
  input  logic              osc_rst_n,
  input  logic              snap_req,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] base_in,
  input  logic [ACC_W-1:0]  frac_in,
  output logic [CNT_W-1:0]  snap_ref,
  output logic [CNT_W-1:0]  snap_osc,
  output logic              snap_valid,
  output logic [CODE_W:0]   dac_code
);
  logic [CNT_W-1:0] osc_gray;
  logic [CNT_W-1:0] osc_bin;
  logic [CNT_W-1:0] ref_cnt;
  logic             cap_q;

  cpm_osc_counter #(.CNT_W(CNT_W)) u_osc (
    .osc_clk  (osc_clk),
    .osc_rst_n(osc_rst_n),
    .gray_o   (osc_gray)
  );

  cpm_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .gray_i(osc_gray),
    .bin_o (osc_bin)
  );

  cpm_dither #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_dith (
    .clk     (ref_clk),
    .rst_n   (ref_rst_n),
    .cfg_load(cfg_load),
    .base_i  (base_in),
    .frac_i  (frac_in),
    .code_o  (dac_code)
  );

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ref_cnt    <= '0;
      cap_q      <= 1'b0;
      snap_ref   <= '0;
      snap_osc   <= '0;
      snap_valid <= 1'b0;
    end else begin
      ref_cnt <= ref_cnt + CNT_W'(1);
      cap_q   <= snap_req;
      if (snap_req) begin
        snap_ref   <= ref_cnt;
        snap_osc   <= osc_bin;
        snap_valid <= 1'b0;
      end else if (cap_q) begin
        snap_valid <= 1'b1;
      end
    end
  end

  // R4
  req_clears_valid_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    snap_req |=> !snap_valid);

  // R4
  valid_follows_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (cap_q && !snap_req) |=> snap_valid);

  // R4
  snap_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !snap_req |=> ($stable(snap_ref) && $stable(snap_osc)));

  // R2
  ref_capture_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    snap_req |=> (snap_ref == $past(ref_cnt)));
endmodule

// File: tb/tb_cnt_pair_dither.sv
`timescale 1ns/1ps
module tb_cnt_pair_dither;
  localparam int CNT_W  = 16;
  localparam int ACC_W  = 8;
  localparam int CODE_W = 10;
  localparam int WIN    = 1 << ACC_W;

  logic              ref_clk = 0, osc_clk = 0;
  logic              rst_n = 0;
  logic              snap_req = 0, cfg_load = 0;
  logic [CODE_W-1:0] base_in = '0;
  logic [ACC_W-1:0]  frac_in = '0;
  logic [CNT_W-1:0]  snap_ref, snap_osc;
  logic              snap_valid;
  logic [CODE_W:0]   dac_code;

  int checks = 0, failures = 0;
  int ref_edges = 0, osc_edges = 0;
  bit done = 0;

  cnt_pair_dither #(.CNT_W(CNT_W), .ACC_W(ACC_W), .CODE_W(CODE_W)) dut (
    .ref_clk(ref_clk), .ref_rst_n(rst_n), .osc_clk(osc_clk), .osc_rst_n(rst_n),
    .snap_req(snap_req), .cfg_load(cfg_load), .base_in(base_in), .frac_in(frac_in),
    .snap_ref(snap_ref), .snap_osc(snap_osc), .snap_valid(snap_valid), .dac_code(dac_code)
  );

  always #5 ref_clk = ~ref_clk;
  always #3.5 osc_clk = ~osc_clk;

  always @(posedge ref_clk) if (!rst_n) ref_edges <= 0; else ref_edges <= ref_edges + 1;
  always @(posedge osc_clk) if (!rst_n) osc_edges <= 0; else osc_edges <= osc_edges + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int carry_at(int i, int f);
    return ((i * f) >> ACC_W) - (((i - 1) * f) >> ACC_W);
  endfunction

  // one full accumulator period; loads next setting mid-way, then wiggles inputs without load
  task automatic run_window(int xc, int fc, int xn, int fn, int xg, int fg);
    int hi = 0, r5e = 0, r6e = 0, r8e = 0, bad_act = 0, bad_exp = 0;
    for (int i = 1; i <= WIN; i++) begin
      int e, g;
      @(negedge ref_clk);
      e = xc + carry_at(i, fc);
      g = int'(dac_code);
      if (g == xc + 1) hi++;
      if (g != xc && g != xc + 1) r5e++;
      if (g != e) begin
        if (r6e == 0) begin bad_act = g; bad_exp = e; end
        r6e++;
        if (i > 100) r8e++;
      end
      if (i == 1) chk(g == e, "R8 first step of period uses loaded setting", g, e);
      if (i == 100) begin base_in = CODE_W'(xn); frac_in = ACC_W'(fn); cfg_load = 1; end
      else if (i == 101) cfg_load = 0;
      else if (i == 150) begin base_in = CODE_W'(xg); frac_in = ACC_W'(fg); end
    end
    chk(r5e == 0, "R5 codes outside {X,X+1}", r5e, 0);
    chk(r6e == 0, "R6 carry position sequence", bad_act, bad_exp);
    chk(r8e == 0, "R8 mid-period load left current period intact", r8e, 0);
    chk(hi == fc, "R7 count of X+1 over one period", hi, fc);
    if (fc == 0) chk(hi == 0 && r6e == 0, "R10 zero fraction keeps X", hi, 0);
    if (xc == (1 << CODE_W) - 1 && fc != 0)
      chk(hi == fc, "R9 X+1 beyond max base does not wrap", hi, fc);
  endtask

  task automatic snap_test(int gap);
    int e_req, osc_now;
    repeat (gap) @(negedge ref_clk);
    snap_req = 1;
    e_req = ref_edges + 1;
    @(negedge ref_clk);
    snap_req = 0;
    osc_now = osc_edges;
    chk(snap_valid == 0, "R4 valid low on capture cycle", snap_valid, 0);
    @(negedge ref_clk);
    chk(snap_valid == 1, "R4 valid high one cycle after capture", snap_valid, 1);
    chk(int'(snap_ref) == e_req - 1, "R2 captured reference count", snap_ref, e_req - 1);
    chk(int'(snap_osc) <= osc_now && int'(snap_osc) + 8 >= osc_now,
        "R3 captured oscillator count near true count", snap_osc, osc_now);
    begin
      logic [CNT_W-1:0] r0, o0;
      r0 = snap_ref; o0 = snap_osc;
      repeat (5) @(negedge ref_clk);
      chk(snap_ref == r0 && snap_osc == o0 && snap_valid == 1,
          "R4 snapshot held without request", snap_osc, o0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      failures++;
      $display("FAIL all-requirements watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int xs[8], fs[8];
    void'($urandom(32'd20240611));
    xs[0] = 0;    fs[0] = 0;
    xs[1] = 300;  fs[1] = 37;
    xs[2] = 5;    fs[2] = 128;
    xs[3] = 1023; fs[3] = 255;
    xs[4] = 77;   fs[4] = 1;
    for (int k = 5; k < 8; k++) begin
      xs[k] = int'($urandom_range(0, 1022));
      fs[k] = int'($urandom_range(0, 255));
    end

    repeat (3) @(negedge ref_clk);
    // R1
    chk(dac_code == 0, "R1 reset dac_code", dac_code, 0);
    chk(snap_ref == 0 && snap_osc == 0, "R1 reset snapshot counts", snap_osc, 0);
    chk(snap_valid == 0, "R1 reset valid", snap_valid, 0);
    rst_n = 1;

    for (int k = 0; k < 8; k++) begin
      int xn, fn;
      xn = (k < 7) ? xs[k+1] : xs[k];
      fn = (k < 7) ? fs[k+1] : fs[k];
      run_window(xs[k], fs[k], xn, fn,
                 int'($urandom_range(0, 1023)), int'($urandom_range(0, 255)));
    end

    @(negedge ref_clk);
    rst_n = 0;
    repeat (3) @(negedge ref_clk);
    chk(snap_valid == 0 && dac_code == 0, "R1 second reset state", dac_code, 0);
    rst_n = 1;
    snap_test(4);
    for (int k = 0; k < 5; k++) snap_test(int'($urandom_range(1, 40)));
    snap_test(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule